// File: doc/BRIEF.md
# Switching-Activity Leakage Estimator

This block watches a word that a register or bus takes on each clock and reports, for each accepted word, the charge and discharge events that a given logic style would spend on it. It also reports the word's Hamming weight, its Hamming distance from the stored reference word, and a linear power figure built from two programmable coefficients. It lets a designer compare, cycle by cycle, how much data-dependent energy each circuit style would expose for the same data stream.

Four styles are modelled. The style code selects one of them:

- 0 is static single-rail logic.
- 1 is static logic with a duplicated complementary rail.
- 2 is precharged single-rail logic.
- 3 is precharged dual-rail logic.

The reference word is the last accepted word, and it is all zeros after reset. Every result is registered. Results appear one cycle after the input strobe, together with a one-cycle result flag.

Top module: `sa_leak_est`

## Requirements
- R1: In style 0, chargeCnt counts the bits that go from 0 in the reference word to 1 in the new word, and dischargeCnt counts the bits that go from 1 to 0. Bits that are unchanged count for nothing.
- R2: After reset the reference word is zero. Each accepted word becomes the reference for the next one, whatever the style. hamDist is the popcount of the reference XOR the new word, and hamWeight is the popcount of the new word, in every style.
- R3: In style 1, chargeCnt and dischargeCnt both equal hamDist.
- R4: In style 2, chargeCnt and dischargeCnt both equal DATA_W minus hamWeight, whatever the previous word was.
- R5: In style 3, chargeCnt and dischargeCnt both equal DATA_W for any data.
- R6: powerEst equals coefA times the metric plus coefB. The metric is hamDist in styles 0 and 1, hamWeight in style 2, and DATA_W in style 3. With coefA = coefB = 255 and DATA_W = 16, the result 4335 is exact and does not overflow.
- R7: Results and a one-cycle outValid pulse appear on the clock edge after the edge that samples inValid high. While inValid is low, the outputs hold their values and the reference word does not change.
- R8: After reset, all outputs are zero and outValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Word on dataIn is accepted this cycle |
| dataIn | input | DATA_W | Observed word |
| styleSel | input | 2 | Logic style: 0 static, 1 static dual-rail, 2 precharged, 3 precharged dual-rail |
| coefA | input | COEF_W | Slope of the power estimate |
| coefB | input | COEF_W | Offset of the power estimate |
| outValid | output | 1 | Results updated this cycle |
| chargeCnt | output | CNT_W | Charge events |
| dischargeCnt | output | CNT_W | Discharge events |
| hamWeight | output | CNT_W | Popcount of the accepted word |
| hamDist | output | CNT_W | Popcount of reference XOR the accepted word |
| powerEst | output | EST_W | coefA times the metric plus coefB |

## Verification
Two things happen on the same edge: the new word is scored against the old reference, and that reference is replaced by the new word. The bench provokes this with back-to-back accepted words and with words split by idle cycles whose data differs. It judges hamDist and the style 0 edge counts against a reference that moves only on accepted words. The bench also changes the style between consecutive accepted words. This checks that the precharged styles ignore the previous word while hamDist still follows it.

// File: rtl/sa_leak_pkg.sv
package sa_leak_pkg;
  typedef enum logic [1:0] {
    STYLE_STATIC   = 2'd0,
    STYLE_DUAL_ST  = 2'd1,
    STYLE_PRE      = 2'd2,
    STYLE_DUAL_PRE = 2'd3
  } style_e;

  typedef struct packed {
    logic capture;
    logic edgeSplit;
    logic railPair;
    logic preSingle;
    logic preDual;
  } leak_ctrl_t;
endpackage

// File: rtl/sa_leak_ctrl.sv
module sa_leak_ctrl
  import sa_leak_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] styleSel,
  output leak_ctrl_t ctrl
);
  style_e style;

  always_comb begin
    style = style_e'(styleSel);
    ctrl = '0;
    ctrl.capture = inValid;
    unique case (style)
      STYLE_STATIC:   ctrl.edgeSplit = 1'b1;
      STYLE_DUAL_ST:  ctrl.railPair  = 1'b1;
      STYLE_PRE:      ctrl.preSingle = 1'b1;
      default:        ctrl.preDual   = 1'b1;
    endcase
  end
endmodule

// File: rtl/sa_leak_datapath.sv
module sa_leak_datapath
  import sa_leak_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 8,
  parameter int CNT_W  = $clog2(DATA_W + 1),
  parameter int EST_W  = COEF_W + CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  leak_ctrl_t        ctrl,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [COEF_W-1:0] coefA,
  input  logic [COEF_W-1:0] coefB,
  output logic              outValid,
  output logic [CNT_W-1:0]  chargeCnt,
  output logic [CNT_W-1:0]  dischargeCnt,
  output logic [CNT_W-1:0]  hamWeight,
  output logic [CNT_W-1:0]  hamDist,
  output logic [EST_W-1:0]  powerEst
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  function automatic logic [CNT_W-1:0] popCount(input logic [DATA_W-1:0] v);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < DATA_W; i++) acc = acc + CNT_W'(v[i]);
    return acc;
  endfunction

  logic [DATA_W-1:0] refQ;
  logic [CNT_W-1:0]  riseN, fallN, distN, weightN, zeroN;
  logic [CNT_W-1:0]  chargeN, dischargeN, metricN;
  logic [EST_W-1:0]  estN;

  always_comb begin
    riseN   = popCount(~refQ & dataIn);
    fallN   = popCount(refQ & ~dataIn);
    distN   = riseN + fallN;
    weightN = popCount(dataIn);
    zeroN   = FULL - weightN;
    if (ctrl.edgeSplit) begin
      chargeN = riseN;  dischargeN = fallN;  metricN = distN;
    end else if (ctrl.railPair) begin
      chargeN = distN;  dischargeN = distN;  metricN = distN;
    end else if (ctrl.preSingle) begin
      chargeN = zeroN;  dischargeN = zeroN;  metricN = weightN;
    end else begin
      chargeN = FULL;   dischargeN = FULL;   metricN = FULL;
    end
    estN = EST_W'(coefA) * EST_W'(metricN) + EST_W'(coefB);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      refQ         <= '0;
      outValid     <= 1'b0;
      chargeCnt    <= '0;
      dischargeCnt <= '0;
      hamWeight    <= '0;
      hamDist      <= '0;
      powerEst     <= '0;
    end else begin
      outValid <= ctrl.capture;
      if (ctrl.capture) begin
        refQ         <= dataIn;
        chargeCnt    <= chargeN;
        dischargeCnt <= dischargeN;
        hamWeight    <= weightN;
        hamDist      <= distN;
        powerEst     <= estN;
      end
    end
  end
endmodule

// File: rtl/sa_leak_est.sv
module sa_leak_est
  import sa_leak_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 8,
  parameter int CNT_W  = $clog2(DATA_W + 1),
  parameter int EST_W  = COEF_W + CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [1:0]        styleSel,
  input  logic [COEF_W-1:0] coefA,
  input  logic [COEF_W-1:0] coefB,
  output logic              outValid,
  output logic [CNT_W-1:0]  chargeCnt,
  output logic [CNT_W-1:0]  dischargeCnt,
  output logic [CNT_W-1:0]  hamWeight,
  output logic [CNT_W-1:0]  hamDist,
  output logic [EST_W-1:0]  powerEst
);
  leak_ctrl_t ctrl;

  sa_leak_ctrl u_ctrl (
    .inValid (inValid),
    .styleSel(styleSel),
    .ctrl    (ctrl)
  );

  sa_leak_datapath #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .CNT_W(CNT_W), .EST_W(EST_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .ctrl        (ctrl),
    .dataIn      (dataIn),
    .coefA       (coefA),
    .coefB       (coefB),
    .outValid    (outValid),
    .chargeCnt   (chargeCnt),
    .dischargeCnt(dischargeCnt),
    .hamWeight   (hamWeight),
    .hamDist     (hamDist),
    .powerEst    (powerEst)
  );
endmodule

// File: rtl/sa_leak_chk.sv
module sa_leak_chk #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 8,
  parameter int CNT_W  = $clog2(DATA_W + 1),
  parameter int EST_W  = COEF_W + CNT_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [1:0]        styleSel,
  input logic              outValid,
  input logic [CNT_W-1:0]  chargeCnt,
  input logic [CNT_W-1:0]  dischargeCnt,
  input logic [CNT_W-1:0]  hamWeight,
  input logic [CNT_W-1:0]  hamDist,
  input logic [EST_W-1:0]  powerEst
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  AST_STATIC_EDGES: assert property (@(posedge clk) disable iff (rst)
    (inValid && styleSel == 2'd0) |=> (chargeCnt + dischargeCnt == hamDist)); // R1
  AST_DUAL_STATIC_BAL: assert property (@(posedge clk) disable iff (rst)
    (inValid && styleSel == 2'd1) |=> (chargeCnt == hamDist && dischargeCnt == hamDist)); // R3
  AST_PRE_ZEROS: assert property (@(posedge clk) disable iff (rst)
    (inValid && styleSel == 2'd2) |=> (dischargeCnt + hamWeight == FULL && chargeCnt == dischargeCnt)); // R4
  AST_DUAL_PRE_CONST: assert property (@(posedge clk) disable iff (rst)
    (inValid && styleSel == 2'd3) |=> (chargeCnt == FULL && dischargeCnt == FULL)); // R5
  AST_RESULT_STROBE: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && $stable(powerEst) && $stable(hamDist))); // R7
endmodule

bind sa_leak_est sa_leak_chk #(
  .DATA_W(DATA_W), .COEF_W(COEF_W), .CNT_W(CNT_W), .EST_W(EST_W)
) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .styleSel(styleSel),
  .outValid(outValid), .chargeCnt(chargeCnt), .dischargeCnt(dischargeCnt),
  .hamWeight(hamWeight), .hamDist(hamDist), .powerEst(powerEst)
);

// File: tb/sa_leak_est_tb.sv
module sa_leak_est_tb;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [N-1:0] dataIn = '0;
  logic [1:0] styleSel = 2'd0;
  logic [7:0] coefA = 8'd3, coefB = 8'd5;
  logic outValid;
  logic [4:0] chargeCnt, dischargeCnt, hamWeight, hamDist;
  logic [13:0] powerEst;

  int checks = 0, failures = 0;
  int refWord = 0;
  int eOv = 0, eCh = 0, eDis = 0, eHw = 0, eHd = 0, eEst = 0;
  logic [31:0] lfsr = 32'h1234_5678;
  bit timedOut = 0;

  always #10 clk = ~clk;

  sa_leak_est u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .dataIn(dataIn),
    .styleSel(styleSel), .coefA(coefA), .coefB(coefB),
    .outValid(outValid), .chargeCnt(chargeCnt), .dischargeCnt(dischargeCnt),
    .hamWeight(hamWeight), .hamDist(hamDist), .powerEst(powerEst)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ones(input int v);
    int c = 0;
    for (int i = 0; i < N; i++) c += (v >> i) & 1;
    return c;
  endfunction

  task automatic compareAll(input string tag);
    chk("R7", {tag, " outValid"}, int'(outValid), eOv);
    chk(tag, "chargeCnt", int'(chargeCnt), eCh);
    chk(tag, "dischargeCnt", int'(dischargeCnt), eDis);
    chk("R2", "hamWeight", int'(hamWeight), eHw);
    chk("R2", "hamDist", int'(hamDist), eHd);
    chk("R6", "powerEst", int'(powerEst), eEst);
  endtask

  // drive one cycle at negedge, update the model, check after the next edge
  task automatic step(input bit v, input int d, input int s);
    string tag;
    int nw, metric;
    inValid = v; dataIn = N'(d); styleSel = 2'(s);
    eOv = 0;
    tag = v ? (s == 0 ? "R1" : s == 1 ? "R3" : s == 2 ? "R4" : "R5") : "R7";
    if (v) begin
      nw = d & 32'hFFFF;
      eOv = 1;
      eHw = ones(nw);
      eHd = ones(nw ^ refWord);
      case (s)
        0: begin eCh = ones(nw & ~refWord); eDis = ones(refWord & ~nw); metric = eHd; end
        1: begin eCh = eHd; eDis = eHd; metric = eHd; end
        2: begin eCh = N - eHw; eDis = N - eHw; metric = eHw; end
        default: begin eCh = N; eDis = N; metric = N; end
      endcase
      eEst = int'(coefA) * metric + int'(coefB);
      refWord = nw;
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    #4_000_000;
    timedOut = 1;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    compareAll("R8");
    // R2: first word measured against zero reference
    step(1, 16'hA5A5, 0);
    step(1, 16'h5A5A, 0);
    // R7: idle cycles with changing data leave the reference alone
    step(0, 16'hFFFF, 0);
    step(0, 16'h0F0F, 2);
    step(1, 16'h5A5B, 0);
    step(1, 16'h00FF, 1);
    step(1, 16'hFF00, 2);
    step(1, 16'h0000, 2);
    step(1, 16'h1234, 3);
    // R6: widest estimate
    coefA = 8'd255; coefB = 8'd255;
    step(1, 16'hFFFF, 3);
    step(1, 16'hFFFF, 2);
    step(1, 16'h0000, 1);
    coefA = 8'd7; coefB = 8'd0;
    for (int k = 0; k < 300 && !timedOut; k++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      if (k % 50 == 0) begin coefA = lfsr[31:24]; coefB = lfsr[23:16]; end
      step(lfsr[20:18] != 3'd0, int'(lfsr[15:0]), int'(lfsr[27:26]));
    end
    if (timedOut) begin
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule